// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block is a byte-wide serial port. Its 8-bit shift register sits between a transmit holding register and a receive holding register. Software-side logic writes a byte into the transmit holding register. The engine moves that byte into the shift register when a transfer begins. Each completed byte lands in the receive holding register, where it stays until it is read. The engine always captures the line while it shifts, so a transmit with the data line looped back also returns the sent byte.

Three framings are available. Clocked-data mode sends eight clock pulses per byte. Two-wire master mode wraps each byte in start and stop conditions and adds a ninth clock for the acknowledge. A reduced two-wire mode keeps the start and stop conditions but has no acknowledge clock. The shift clock comes from one of several external tick inputs. Each tick advances the line by half a bit period. A single interrupt output can be set to fire either when a holding register is serviced or when a whole transfer ends. The data output register is also exported so that an external modulator can use it.

Top module: `ssi_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `sc_out`=1, `sd_oe`=0, `active`=0, `tx_ready`=0, `rx_ready`=0, `irq`=0 and `rack`=0.
- R2: Writing the transmit holding register sets `tx_ready`. With `dir`=1 a transfer starts only while `tx_ready` is 1, and `tx_ready` clears in the cycle the byte moves into the shift register.
- R3: A `tx_wr` while `tx_ready` is 1 is ignored. The byte already held is the one that is sent.
- R4: In clocked-data mode (`mode` 00 or 11) each byte takes 8 clock pulses, MSB first. The output bit changes as `sc_out` falls and the input is sampled as `sc_out` rises. The sampled byte is written to the receive holding register, so a looped-back transmit returns the same byte.
- R5: In the two-wire modes (`mode` 01 or 10) every byte is framed by a start condition and a stop condition. A start is the data line falling while `sc_out` is high. A stop is the data line rising while `sc_out` is high. At any other time the data line changes only while `sc_out` is low. The idle bus is driven high.
- R6: In `mode` 01 a 9th clock carries the acknowledge. A transmitting master releases the line and sets `rack` to 1 if the line was low. A receiving master drives the line low when `tack`=1 and high when `tack`=0. Each byte takes 10 `sc_out` rises, counting the stop.
- R7: In `mode` 10 there is no acknowledge clock. Each byte takes 9 `sc_out` rises, counting the stop, and `rack` keeps its value.
- R8: With `ifn`=0, `irq` pulses one cycle after the transmit byte is taken (`dir`=1) or after a byte is stored (`dir`=0). With `ifn`=1 it pulses one cycle after a transfer ends, in step with `active` falling.
- R9: `rx_ready` sets when a byte is stored and clears after `rx_rd`. `rx_data` holds the stored byte.
- R10: While `en` is 0 no transfer starts. A transfer already under way completes.
- R11: `sc_out` changes only on ticks of the source picked by `clk_sel`. With ticks every P cycles, a clocked-data byte keeps `active` high for about 16·P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_src | input | NSRC | Candidate shift-tick strobes |
| clk_sel | input | SEL_W | Index of the tick strobe in use |
| en | input | 1 | Allows new transfers to start |
| mode | input | 2 | 00/11 clocked data, 01 two-wire with ack, 10 two-wire without ack |
| dir | input | 1 | 1 transmit, 0 receive |
| ifn | input | 1 | Interrupt source: 0 buffer service, 1 end of transfer |
| tack | input | 1 | Acknowledge to drive as receiving master |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DW | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_data | output | DW | Last stored byte |
| tx_ready | output | 1 | Transmit holding register is loaded |
| rx_ready | output | 1 | Receive holding register holds an unread byte |
| active | output | 1 | Transfer in progress |
| rack | output | 1 | Acknowledge seen on the last 9-bit transmit |
| sc_out | output | 1 | Serial clock |
| sd_out | output | 1 | Serial data output value |
| sd_oe | output | 1 | Serial data output enable |
| sd_in | input | 1 | Serial data line as seen at the pin |
| so_bit | output | 1 | Data output bit for an external modulator |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with its defaults: DW=8 and NSRC=2. The two tick sources run at periods of 4 and 8 cycles, so the clock select visibly changes the transfer length. The bench sends bytes in all three framings with the data line looped back. A bench-side bus watcher counts clock rises and start and stop conditions, and a slave model answers acknowledges and feeds receive patterns. Back-to-back transmits, a write into a full holding register, and both interrupt timings are all within reach at these sizes.

// File: rtl/ssi_pkg.sv
// Shared types for the serial port: framing modes and engine states.
package ssi_pkg;
    typedef enum logic [1:0] {
        M_SYNC  = 2'b00,
        M_TW9   = 2'b01,
        M_TW8   = 2'b10,
        M_SYNC2 = 2'b11
    } ssi_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_BIT_LO, S_BIT_HI, S_STOP_A, S_STOP_B, S_STOP_C
    } ssi_state_e;

    // True for the framings that use start/stop conditions.
    function automatic logic is_two_wire(ssi_mode_e m);
        return (m == M_TW9) || (m == M_TW8);
    endfunction
endpackage

// File: rtl/ssi_tick_sel.sv
// Picks one shift-tick strobe out of NSRC candidates.
// Assumes each source is a one-cycle strobe; an index beyond NSRC gives no tick.
module ssi_tick_sel #(
    parameter int NSRC  = 2,
    parameter int SEL_W = 1
) (
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    // Multiplex the selected strobe.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) tick = tick_src[i];
        end
    end
endmodule

// File: rtl/ssi_buffers.sv
// Transmit and receive holding registers, their flags, and the interrupt pulse.
// Assumes load/cap/xfer_end are single-cycle strobes from the engine.
module ssi_buffers #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          load,
    output logic          tx_full,
    output logic [DW-1:0] tx_buf,
    input  logic          rx_rd,
    input  logic          cap,
    input  logic [DW-1:0] cap_byte,
    output logic          rx_full,
    output logic [DW-1:0] rx_buf,
    input  logic          ifn,
    input  logic          xfer_end,
    input  logic          dir_q,
    output logic          irq
);
    // Transmit holding register: accepts a write only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_buf  <= '0;
        end else if (load) begin
            tx_full <= 1'b0;
        end else if (tx_wr && !tx_full) begin
            tx_full <= 1'b1;
            tx_buf  <= tx_data;
        end
    end

    // Receive holding register: a capture wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_buf  <= '0;
        end else if (cap) begin
            rx_full <= 1'b1;
            rx_buf  <= cap_byte;
        end else if (rx_rd) begin
            rx_full <= 1'b0;
        end
    end

    // Interrupt pulse, one cycle after the chosen event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= ifn ? xfer_end : (load | (cap & ~dir_q));
    end

    p_full_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_wr && !load) |=> ($stable(tx_buf) && tx_full));
    p_capture_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (rx_full && rx_buf == $past(cap_byte)));
    p_load_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tx_full);
endmodule

// File: rtl/ssi_engine.sv
// Bit engine: frames one byte per transfer in the latched mode and direction.
// Each tick advances one half bit. The line is sampled on the rising clock.
// Assumes the tick is a one-cycle strobe. Mode and direction are latched at start.
module ssi_engine
    import ssi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  ssi_mode_e     mode,
    input  logic          dir,
    input  logic          tack,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_byte,
    input  logic          sd_in,
    output logic          load,
    output logic          cap,
    output logic [DW-1:0] cap_byte,
    output logic          xfer_end,
    output logic          dir_q,
    output logic          active,
    output logic          rack,
    output logic          sc_out,
    output logic          sd_out,
    output logic          sd_oe
);
    localparam int CW = $clog2(DW + 1);

    ssi_state_e     state;
    ssi_mode_e      mode_q;
    logic [DW-1:0]  shift;
    logic [CW-1:0]  bitcnt;
    logic [CW-1:0]  last_idx;
    logic           tw;
    logic           go;

    // Start decision and the strobes handed to the buffers.
    always_comb begin
        tw       = is_two_wire(mode_q);
        last_idx = (mode_q == M_TW9) ? CW'(DW) : CW'(DW - 1);
        go       = (state == S_IDLE) && en && (!dir || tx_full);
        load     = go && dir;
        cap      = tick && (state == S_BIT_HI) && (bitcnt == CW'(DW - 1));
        cap_byte = {shift[DW-2:0], sd_in};
        xfer_end = tick && (((state == S_BIT_HI) && (bitcnt == last_idx) && !tw)
                            || (state == S_STOP_C));
    end

    // Framing state machine, clock and data drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode_q <= M_SYNC;
            dir_q  <= 1'b0;
            shift  <= '0;
            bitcnt <= '0;
            active <= 1'b0;
            rack   <= 1'b0;
            sc_out <= 1'b1;
            sd_out <= 1'b1;
            sd_oe  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    sd_out <= 1'b1;
                    sd_oe  <= is_two_wire(mode);
                    if (go) begin
                        mode_q <= mode;
                        dir_q  <= dir;
                        active <= 1'b1;
                        bitcnt <= '0;
                        if (dir) shift <= tx_byte;
                        state  <= is_two_wire(mode) ? S_START : S_BIT_LO;
                    end
                end
                S_START: if (tick) begin
                    sd_out <= 1'b0;
                    sd_oe  <= 1'b1;
                    state  <= S_BIT_LO;
                end
                S_BIT_LO: if (tick) begin
                    sc_out <= 1'b0;
                    if (bitcnt < CW'(DW)) begin
                        sd_out <= dir_q ? shift[DW-1] : 1'b1;
                        sd_oe  <= dir_q;
                    end else begin
                        sd_out <= dir_q ? 1'b1 : ~tack;
                        sd_oe  <= ~dir_q;
                    end
                    state <= S_BIT_HI;
                end
                S_BIT_HI: if (tick) begin
                    sc_out <= 1'b1;
                    if (bitcnt < CW'(DW)) shift <= {shift[DW-2:0], sd_in};
                    else if (dir_q)       rack  <= ~sd_in;
                    if (bitcnt == last_idx) begin
                        if (tw) begin
                            state <= S_STOP_A;
                        end else begin
                            state  <= S_IDLE;
                            active <= 1'b0;
                            sd_out <= 1'b1;
                            sd_oe  <= 1'b0;
                        end
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        state  <= S_BIT_LO;
                    end
                end
                S_STOP_A: if (tick) begin
                    sc_out <= 1'b0;
                    sd_out <= 1'b0;
                    sd_oe  <= 1'b1;
                    state  <= S_STOP_B;
                end
                S_STOP_B: if (tick) begin
                    sc_out <= 1'b1;
                    state  <= S_STOP_C;
                end
                S_STOP_C: if (tick) begin
                    sd_out <= 1'b1;
                    active <= 1'b0;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_clock_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sc_out) |-> $past(tick));
    p_tx_needs_buffer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && dir_q) |-> $past(tx_full));
    p_start_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(en));
    p_line_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_two_wire(mode_q) && sc_out && $past(sc_out) && (sd_out != $past(sd_out))
         && ($past(state) != S_IDLE))
        |-> (($past(state) == S_START) || ($past(state) == S_STOP_C)));
    p_ack_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BIT_HI) && (bitcnt == CW'(DW))) |-> (sd_oe != dir_q));
    p_no_ack_keeps_rack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_TW9) |=> $stable(rack));
endmodule

// File: rtl/ssi_port.sv
// Top of the buffered serial port: tick select, holding registers, bit engine.
// Assumes the pin logic resolves sd_out/sd_oe into sd_in; clock sources are external.
module ssi_port
    import ssi_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NSRC  = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic             dir,
    input  logic             ifn,
    input  logic             tack,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_data,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_data,
    output logic             tx_ready,
    output logic             rx_ready,
    output logic             active,
    output logic             rack,
    output logic             sc_out,
    output logic             sd_out,
    output logic             sd_oe,
    input  logic             sd_in,
    output logic             so_bit,
    output logic             irq
);
    logic          tick, load, cap, xfer_end, dir_q;
    logic [DW-1:0] tx_buf, cap_byte;

    ssi_tick_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_tick (
        .tick_src(tick_src), .sel(clk_sel), .tick(tick)
    );

    ssi_buffers #(.DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
        .load(load), .tx_full(tx_ready), .tx_buf(tx_buf),
        .rx_rd(rx_rd), .cap(cap), .cap_byte(cap_byte),
        .rx_full(rx_ready), .rx_buf(rx_data),
        .ifn(ifn), .xfer_end(xfer_end), .dir_q(dir_q), .irq(irq)
    );

    ssi_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
        .mode(ssi_mode_e'(mode)), .dir(dir), .tack(tack),
        .tx_full(tx_ready), .tx_byte(tx_buf), .sd_in(sd_in),
        .load(load), .cap(cap), .cap_byte(cap_byte), .xfer_end(xfer_end),
        .dir_q(dir_q), .active(active), .rack(rack),
        .sc_out(sc_out), .sd_out(sd_out), .sd_oe(sd_oe)
    );

    // Modulators take the registered data output bit.
    assign so_bit = sd_out;

    p_end_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(ifn)) |-> $fell(active));
    p_reset_state_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (sc_out && !sd_oe && !active && !tx_ready && !rx_ready && !irq && !rack));
endmodule

// File: tb/ssi_port_test.sv
// Scoreboard bench: tasks queue expected bytes, a negedge monitor pops and compares.
module ssi_port_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] tick_src;
    logic [0:0] clk_sel = '0;
    logic       en = 0, dir = 0, ifn = 0, tack = 0, tx_wr = 0, rx_rd = 0;
    logic [1:0] mode = 2'b00;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       tx_ready, rx_ready, active, rack, sc_out, sd_out, sd_oe, so_bit, irq;
    logic       sd_in;
    logic       slave_drive = 1'b1;
    logic       ack_level = 1'b1, slave_mode = 1'b0, mon_clr = 1'b0;
    logic [15:0] pat = '0;
    logic [2:0] tcnt = '0;

    always @(posedge clk) tcnt <= tcnt + 3'd1;
    assign tick_src[0] = (tcnt[1:0] == 2'd0);
    assign tick_src[1] = (tcnt == 3'd0);
    assign sd_in = sd_oe ? sd_out : slave_drive;

    ssi_port uut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .clk_sel(clk_sel),
        .en(en), .mode(mode), .dir(dir), .ifn(ifn), .tack(tack),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .active(active), .rack(rack),
        .sc_out(sc_out), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
        .so_bit(so_bit), .irq(irq)
    );

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] expq[$];
    int rises, starts, stops, irqs, act_cyc, rx_got, sidx;
    logic [15:0] hist;
    logic p_sc = 1'b1, p_sd = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard on received bytes, bus watcher, slave data model.
    always @(negedge clk) begin
        if (rx_rd) begin
            rx_rd = 1'b0;
            chk(!rx_ready, "R9 ready cleared by read", int'(rx_ready), 0);
        end else if (rx_ready && rst_n) begin
            if (expq.size() == 0) chk(0, "R4 unexpected byte", int'(rx_data), 0);
            else begin
                automatic logic [7:0] e = expq.pop_front();
                chk(rx_data == e, "R4 R9 received byte", int'(rx_data), int'(e));
            end
            rx_got++;
            rx_rd = 1'b1;
        end
        if (mon_clr) begin
            rises = 0; starts = 0; stops = 0; irqs = 0; act_cyc = 0; sidx = 0; hist = '0;
        end else begin
            if (sc_out && !p_sc) begin rises++; hist = {hist[14:0], sd_in}; end
            if (sc_out && p_sc && p_sd && !sd_in) starts++;
            if (sc_out && p_sc && !p_sd && sd_in) stops++;
            if (irq) irqs++;
            if (active) act_cyc++;
        end
        if (!slave_mode) slave_drive = ack_level;
        else if (p_sc && !sc_out) begin
            slave_drive = pat[15 - (sidx % 16)];
            sidx++;
        end
        p_sc = sc_out;
        p_sd = sd_in;
    end

    task automatic clr_mon();
        @(negedge clk); #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); #1 tx_wr = 1'b1; tx_data = b;
        @(negedge clk); #1 tx_wr = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (active || tx_ready) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic rx_one_frame();
        @(negedge clk); #1 en = 1'b1;
        while (!active) @(negedge clk);
        #1 en = 1'b0;
        while (active) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int a0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sc_out == 1 && sd_oe == 0, "R1 clock high, line released", int'({sc_out, sd_oe}), 2);
        chk(!active && !tx_ready && !rx_ready, "R1 flags clear", int'({active, tx_ready, rx_ready}), 0);
        chk(!irq && !rack, "R1 irq and rack clear", int'({irq, rack}), 0);
        #1 rst_n = 1'b1;

        // R2: transmit mode, enabled, empty buffer: nothing starts
        dir = 1'b1; en = 1'b1;
        repeat (50) @(negedge clk);
        chk(!active && rises == 0, "R2 no start without loaded buffer", int'(active), 0);

        // R10 / R3: disabled, buffer loaded, second write ignored
        #1 en = 1'b0;
        wr(8'hA5);
        chk(tx_ready, "R2 ready set by write", int'(tx_ready), 1);
        wr(8'h3C);
        repeat (50) @(negedge clk);
        chk(!active, "R10 no start while disabled", int'(active), 0);
        expq.push_back(8'hA5);
        clr_mon();
        #1 ifn = 1'b0; en = 1'b1;
        wait_done();
        chk(rises == 8, "R4 eight clock pulses", rises, 8);
        chk(irqs == 1, "R8 irq on buffer take", irqs, 1);
        chk(act_cyc >= 60 && act_cyc <= 68, "R11 length with fast source", act_cyc, 64);
        chk(expq.size() == 0, "R3 held byte sent, late write dropped", expq.size(), 0);
        a0 = act_cyc;

        // R11: slower source
        #1 clk_sel = 1'b1;
        clr_mon();
        expq.push_back(8'h81);
        wr(8'h81);
        wait_done();
        chk(act_cyc >= 120 && act_cyc <= 136 && act_cyc > a0, "R11 length with slow source", act_cyc, 128);
        #1 clk_sel = 1'b0;

        // R4 / R8: back-to-back bytes
        clr_mon();
        expq.push_back(8'h81); expq.push_back(8'h7E);
        wr(8'h81);
        while (tx_ready) @(negedge clk);
        wr(8'h7E);
        wait_done();
        chk(rises == 16, "R4 two bytes back to back", rises, 16);
        chk(irqs == 2, "R8 irq per buffer take", irqs, 2);

        // R5 / R6 / R8: two-wire with acknowledge, slave acks
        #1 mode = 2'b01; ifn = 1'b1; ack_level = 1'b0;
        repeat (3) @(negedge clk);
        clr_mon();
        expq.push_back(8'hC3);
        wr(8'hC3);
        wait_done();
        chk(starts == 1 && stops == 1, "R5 one start and one stop", starts * 16 + stops, 17);
        chk(rises == 10, "R6 nine clocks plus stop", rises, 10);
        chk(rack == 1, "R6 ack seen", int'(rack), 1);
        chk(irqs == 1, "R8 irq at end of transfer", irqs, 1);

        #1 ack_level = 1'b1;
        clr_mon();
        expq.push_back(8'h55);
        wr(8'h55);
        wait_done();
        chk(rack == 0, "R6 missing ack seen", int'(rack), 0);

        // R7: two-wire without acknowledge; slave would ack, rack must stay 0
        #1 mode = 2'b10; ack_level = 1'b0;
        repeat (3) @(negedge clk);
        clr_mon();
        expq.push_back(8'h96);
        wr(8'h96);
        wait_done();
        chk(rises == 9, "R7 eight clocks plus stop", rises, 9);
        chk(starts == 1 && stops == 1, "R7 R5 framing kept", starts * 16 + stops, 17);
        chk(rack == 0, "R7 rack unchanged", int'(rack), 0);

        // R6 receive side: master drives the ack from tack
        #1 mode = 2'b01; dir = 1'b0; tack = 1'b1; ack_level = 1'b1; ifn = 1'b0;
        repeat (3) @(negedge clk);
        clr_mon();
        expq.push_back(8'hFF);
        rx_one_frame();
        chk(rises == 10 && hist[1] == 1'b0, "R6 receiver drives ack low", int'(hist[1]), 0);
        #1 tack = 1'b0;
        clr_mon();
        expq.push_back(8'hFF);
        rx_one_frame();
        chk(hist[1] == 1'b1, "R6 receiver leaves ack high", int'(hist[1]), 1);

        // R4 / R9 / R10: clocked-data receive of two bytes from the slave model
        #1 mode = 2'b00; pat = 16'h5AE1; slave_mode = 1'b1;
        repeat (3) @(negedge clk);
        clr_mon();
        expq.push_back(8'h5A); expq.push_back(8'hE1);
        a0 = rx_got;
        #1 en = 1'b1;
        while (rx_got == a0) @(negedge clk);
        while (!active) @(negedge clk);
        #1 en = 1'b0;
        while (active) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(rises == 16, "R10 byte under way completes", rises, 16);
        chk(irqs == 2, "R8 irq per stored byte", irqs, 2);
        chk(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule